// File: doc/BRIEF.md
# Triggered Probe Capture Core

This block is an on-chip capture engine for watching a bundle of internal signals. All of its logic runs on one sampling clock. Software first sets a trigger condition for each probed channel and a post-trigger length, then pulses `arm`. While armed, the core writes one probe sample per clock into a circular block-RAM buffer. It keeps doing so until the channel conditions are all met in the same sample.

After the trigger it stores a set number of further samples and then freezes. The stored window holds history from before the trigger, the trigger sample itself and the samples that follow it. Software polls `status` or `done`, then walks `rd_idx` from 0 upward to read the window oldest sample first. `trig_idx` gives the position of the trigger sample, which serves as time zero.

The state machine has four states. IDLE goes to ARMED on `arm`. ARMED goes to POST_TRIGGER on a qualified trigger when the post length is nonzero, or goes straight to DONE when the post length is zero. POST_TRIGGER goes to DONE once the last post-trigger sample is written. DONE holds until the next `arm`. An `arm` pulse in any state restarts the capture in ARMED.

Top module: `probe_capture`

## Requirements
- R1: After reset, `status` reads 0 (IDLE) and `done` is low. The status encoding is IDLE=0, ARMED=1, POST_TRIGGER=2, DONE=3.
- R2: A pulse on `arm` makes `status` read 1 (ARMED) after the next clock edge. The core latches `post_len` at that edge.
- R3: Channel i uses bits [3i+2:3i] of `cond_cfg` as its trigger code: 0 don't care, 1 rising, 2 falling, 3 high, 4 low. Codes 5, 6 and 7 behave as don't care.
- R4: The trigger fires only in a sample where every channel's condition holds at once. If no such sample occurs, the core stays ARMED.
- R5: A rising or falling edge is judged against the probe value sampled on the previous clock edge.
- R6: The k-th sample stored after arming (k from 0) may trigger only when k >= DEPTH-1-post_len. An all-don't-care setting therefore triggers on exactly that sample.
- R7: After the trigger sample, exactly `post_len` further samples are stored. For a trigger on sample k, DONE appears after clock edge 1+k+post_len, counting the arming edge as edge 0. DONE holds until the next `arm`.
- R8: In DONE, `rd_data` presents, one clock after `rd_idx` is set, the stored sample at position `rd_idx` of the window, where 0 is the oldest. The window covers samples k-(DEPTH-1-post_len) through k+post_len.
- R9: In DONE, `trig_idx` equals DEPTH-1-post_len, the window position of the trigger sample.
- R10: An `arm` pulse while ARMED or DONE restarts the capture from an empty history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start or restart a capture |
| probe | input | CH | Probed signal vector |
| cond_cfg | input | 3*CH | Per-channel trigger codes |
| post_len | input | AW | Samples stored after the trigger sample |
| rd_idx | input | AW | Readout position, 0 = oldest |
| rd_data | output | CH | Sample at rd_idx, one clock latency |
| trig_idx | output | AW | Window position of the trigger sample |
| status | output | 2 | Current state code |
| done | output | 1 | Capture complete |

## Verification
The bench sweeps every channel through every condition code, at post lengths of 0, 6 and 15, against several probe patterns. For each run it predicts the trigger sample from its own model of the conditions and pre-fill gate. A core that let the trigger through before the pre-trigger history filled would end DONE too early, and its window would start in data left over from an earlier run. An edge detector compared against the wrong sample would trigger one sample off, so every stored word would shift. Impossible AND combinations must leave the core parked in ARMED. The unused codes must act as don't care, or the all-channel run would never finish.

// File: rtl/probe_capture_pkg.sv
package probe_capture_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_t;

    localparam logic [2:0] COND_ANY  = 3'd0;
    localparam logic [2:0] COND_RISE = 3'd1;
    localparam logic [2:0] COND_FALL = 3'd2;
    localparam logic [2:0] COND_HIGH = 3'd3;
    localparam logic [2:0] COND_LOW  = 3'd4;

endpackage

// File: rtl/probe_trigger.sv
module probe_trigger
    import probe_capture_pkg::*;
#(
    parameter int CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH-1:0]   cur,
    input  logic [3*CH-1:0] cfg,
    output logic            hit
);

    logic [CH-1:0] prev_q;
    logic [CH-1:0] ch_ok;

    // previous sample, held every clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    for (genvar i = 0; i < CH; i++) begin : g_chan
        logic [2:0] code;
        assign code = cfg[3*i +: 3];
        always_comb begin
            case (code)
                COND_RISE: ch_ok[i] =  cur[i] && !prev_q[i];
                COND_FALL: ch_ok[i] = !cur[i] &&  prev_q[i];
                COND_HIGH: ch_ok[i] =  cur[i];
                COND_LOW:  ch_ok[i] = !cur[i];
                default:   ch_ok[i] = 1'b1;
            endcase
        end
    end

    assign hit = &ch_ok;

endmodule

// File: rtl/capture_ram.sv
module capture_ram #(
    parameter int W     = 4,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/probe_capture.sv
module probe_capture
    import probe_capture_pkg::*;
#(
    parameter int CH    = 4,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [CH-1:0]   probe,
    input  logic [3*CH-1:0] cond_cfg,
    input  logic [AW-1:0]   post_len,
    input  logic [AW-1:0]   rd_idx,
    output logic [CH-1:0]   rd_data,
    output logic [AW-1:0]   trig_idx,
    output logic [1:0]      status,
    output logic            done
);

    localparam logic [AW-1:0] LAST_POS = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);

    cap_state_t    state_q, state_d;
    logic [AW-1:0] wr_ptr_q, trig_addr_q, post_q, pre_q, left_q;
    logic [AW:0]   fill_q;
    logic          wr_en, fire, trig_hit, prefill_ok;

    probe_trigger #(.CH(CH)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (probe),
        .cfg   (cond_cfg),
        .hit   (trig_hit)
    );

    capture_ram #(.W(CH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr_q),
        .wdata (probe),
        .raddr (wr_ptr_q + rd_idx),
        .rdata (rd_data)
    );

    assign prefill_ok = fill_q >= {1'b0, pre_q};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and write strobes
    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!arm) begin
                    wr_en = 1'b1;
                    if (trig_hit && prefill_ok) begin
                        fire    = 1'b1;
                        state_d = (post_q == '0) ? ST_DONE : ST_POST;
                    end
                end
            end
            ST_POST: begin
                if (arm) state_d = ST_ARMED;
                else begin
                    wr_en = 1'b1;
                    if (left_q == AW'(1)) state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (arm) state_d = ST_ARMED;
            end
        endcase
    end

    // capture datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q    <= '0;
            trig_addr_q <= '0;
            post_q      <= '0;
            pre_q       <= LAST_POS;
            left_q      <= '0;
            fill_q      <= '0;
        end else if (arm) begin
            wr_ptr_q <= '0;
            fill_q   <= '0;
            post_q   <= post_len;
            pre_q    <= LAST_POS - post_len;
        end else begin
            if (wr_en) begin
                wr_ptr_q <= wr_ptr_q + AW'(1);
                if (fill_q < FULL_CNT) fill_q <= fill_q + 1'b1;
            end
            if (fire) begin
                trig_addr_q <= wr_ptr_q;
                left_q      <= post_q;
            end else if (state_q == ST_POST) begin
                left_q <= left_q - AW'(1);
            end
        end
    end

    assign trig_idx = trig_addr_q - wr_ptr_q;
    assign status   = state_q;
    assign done     = (state_q == ST_DONE);

    // R2
    idle_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> state_q == ST_ARMED);

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !arm) |=> state_q == ST_DONE);

    // R6
    prefill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ARMED && !$past(arm) && state_q != ST_ARMED)
        |-> $past(fill_q) >= {1'b0, $past(pre_q)});

    // R9
    trig_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> trig_idx == pre_q);

endmodule

// File: tb/probe_capture_test.sv
module probe_capture_test;

    localparam int CH    = 4;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            arm;
    logic [CH-1:0]   probe;
    logic [3*CH-1:0] cond_cfg;
    logic [AW-1:0]   post_len;
    logic [AW-1:0]   rd_idx;
    logic [CH-1:0]   rd_data;
    logic [AW-1:0]   trig_idx;
    logic [1:0]      status;
    logic            done;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    probe_capture #(.CH(CH), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe),
        .cond_cfg(cond_cfg), .post_len(post_len), .rd_idx(rd_idx),
        .rd_data(rd_data), .trig_idx(trig_idx), .status(status), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [CH-1:0] pv(input int pat, input int t);
        case (pat)
            0:       return CH'(t);
            1:       return CH'(t * 7 + 3);
            2:       return CH'(t ^ (t >> 1));
            default: return (t % 2 == 1) ? CH'(1) : CH'(2);
        endcase
    endfunction

    function automatic bit all_match(input logic [3*CH-1:0] cfg,
                                     input logic [CH-1:0] c, input logic [CH-1:0] p);
        for (int i = 0; i < CH; i++) begin
            int code = int'(cfg[3*i +: 3]);
            bit ok;
            case (code)
                1:       ok = c[i] && !p[i];
                2:       ok = !c[i] && p[i];
                3:       ok = c[i];
                4:       ok = !c[i];
                default: ok = 1'b1;
            endcase
            if (!ok) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic capture(input logic [3*CH-1:0] cfg, input int post, input int pat,
                           input string req);
        int pre = DEPTH - 1 - post;
        int st  = -1;
        int n;
        for (int s = pre; s < 200; s++) begin
            if (all_match(cfg, pv(pat, s + 1), pv(pat, s))) begin
                st = s;
                break;
            end
        end
        @(negedge clk);
        cond_cfg = cfg; post_len = AW'(post); arm = 1'b1; probe = pv(pat, 0);
        @(negedge clk);
        arm = 1'b0; probe = pv(pat, 1);
        // R2 / R10: armed after arming edge
        check(status == 2'd1, "R2/R10 armed", int'(status), 1);
        if (st < 0) begin
            for (int k = 1; k <= 60; k++) begin
                @(negedge clk);
                probe = pv(pat, k + 1);
            end
            // R4: unreachable AND keeps ARMED
            check(status == 2'd1, "R4 no trigger", int'(status), 1);
            return;
        end
        n = 0;
        for (int k = 1; k < 260; k++) begin
            @(negedge clk);
            n = k;
            if (status == 2'd3) break;
            probe = pv(pat, k + 1);
        end
        // R7 / R6 / R5: done exactly after edge 1+st+post
        check(n == 1 + st + post, {req, " R7 done edge"}, n, 1 + st + post);
        // R9
        check(int'(trig_idx) == pre, {req, " R9 trig_idx"}, int'(trig_idx), pre);
        for (int i = 0; i < DEPTH; i++) begin
            logic [CH-1:0] e;
            rd_idx = AW'(i);
            @(negedge clk);
            e = pv(pat, 1 + st - pre + i);
            // R8
            check(rd_data == e, {req, " R8 window"}, int'(rd_data), int'(e));
        end
        // R7: still DONE
        check(status == 2'd3 && done, {req, " R7 hold"}, int'(status), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; arm = 1'b0; probe = '0; cond_cfg = '0; post_len = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(status == 2'd0 && !done, "R1 reset idle", int'(status), 0);

        // R6: all don't care triggers exactly at pre-fill limit
        capture('0, 0, 0, "R6 dc");
        capture('0, 7, 1, "R6 dc");
        capture('0, 15, 2, "R6 dc");

        // R3: unused codes act as don't care
        capture({3'd5, 3'd6, 3'd7, 3'd5}, 4, 0, "R3 unused");

        // R3 / R5: every channel, every code, several post lengths and patterns
        for (int pat = 0; pat < 3; pat++)
            for (int ch = 0; ch < CH; ch++)
                for (int code = 1; code <= 4; code++)
                    for (int pi = 0; pi < 3; pi++) begin
                        logic [3*CH-1:0] cfg = '0;
                        int post = (pi == 0) ? 0 : (pi == 1) ? 6 : 15;
                        cfg[3*ch +: 3] = 3'(code);
                        capture(cfg, post, pat, "R3/R5 sweep");
                    end

        // R4: AND of several channels
        capture({3'd0, 3'd1, 3'd0, 3'd3}, 5, 0, "R4 and");
        capture({3'd4, 3'd0, 3'd2, 3'd0}, 9, 2, "R4 and");
        capture({3'd0, 3'd0, 3'd3, 3'd3}, 3, 3, "R4 never");
        // R10: re-arm from ARMED after a stuck run
        capture('0, 2, 1, "R10 rearm");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule